// File: doc/BRIEF.md
# Flash Operation Status Generator

This block produces the status byte that a NOR-style flash places on its data bus while an internal program or erase runs. It holds the set of sectors chosen for erasure and the current mode: idle, acceptance window, active erase, erase suspended, program, or program during suspend. It also runs a window timer for sector erase acceptance and counts internal pulses to decide when an operation finishes or fails. The flash array, the unlock-sequence decoder and the analog behaviour sit outside it.

Commands arrive as one-cycle strobes (`cmdValid` with a 3-bit code), each standing for the end of a complete command sequence. Read cycles come in on the two active-low selects. Whenever the block is not reporting status, `dataOut` passes `arrayData` through unchanged. The acceptance window, the program and erase durations and the pulse limit are parameters counted in clock cycles. `NUM_SECTORS` must be a power of two.

Top module: `flash_op_status`

## Requirements
- R1: During and after reset, and in idle mode, `dataOut` equals `arrayData`. It also equals `arrayData` once an operation has completed.
- R2: Bit 2 of the status byte inverts on each read cycle whose `rdSector` is selected for erase. This holds in the acceptance window, in active erase and in erase suspend. Reads of other sectors leave it unchanged.
- R3: Bit 6 inverts on every read cycle during the acceptance window, active erase, program and program-in-suspend, whatever sector is addressed. It holds its value throughout erase suspend.
- R4: After a sector-erase command, bit 3 reads 0 for `TIMEOUT_CYC` cycles and then reads 1. A further sector-erase command before bit 3 reads 1 adds its sector and restarts the full window. This includes a command that arrives in the cycle the window would have closed.
- R5: A chip-erase command selects every sector and starts the erase at once, with bit 3 reading 1 from the first cycle.
- R6: While the erase is active, every command except erase-suspend is ignored.
- R7: A program completes `PGM_CYC` cycles after its command. If any bit of `pgmNew` is 1 where `pgmOld` is 0, the program instead stalls. `PULSE_LIMIT` cycles after the command, bit 5 becomes 1, and bit 6 keeps inverting on reads.
- R8: After a failed program, a reset command returns the block to array read. If the failed program was started from erase suspend, the reset returns it to erase suspend instead.
- R9: A read cycle begins in the cycle where both `ceN` and `oeN` are low, provided they were not both low in the cycle before. Either select may be the one that falls last.
- R10: An erase completes after `ERASE_CYC` cycles of active erase; cycles spent in suspend do not count. The selection is then cleared and array read resumes.
- R11: An accepted sector-erase (from idle), chip-erase or program command clears bits 6 and 2 to 0. The status byte is {0, bit6, bit5, 0, bit3, bit2, 0, 0}, and all bits above bit 7 are 0.
- R12: Command codes are 1 sector erase, 2 chip erase, 3 erase suspend, 4 erase resume, 5 program and 6 reset. Codes 0 and 7, and any command not valid in the current mode, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle strobe marking a complete command |
| cmdCode | input | 3 | Command code (see R12) |
| cmdSector | input | log2(NUM_SECTORS) | Sector named by a sector-erase command |
| pgmNew | input | DATA_W | Data a program command writes |
| pgmOld | input | DATA_W | Current content of the program location |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| rdSector | input | log2(NUM_SECTORS) | Sector of the address being read |
| arrayData | input | DATA_W | Array data for non-status reads |
| dataOut | output | DATA_W | Status byte or array data |

## Verification
Two events can meet on the same clock edge. One pair is a further sector-erase command and the closing of the acceptance window; the other pair is a read start and a toggle-clearing command. The first pair is provoked directly: the bench issues the second sector-erase exactly `TIMEOUT_CYC` cycles after the first, then checks that bit 3 still reads 0 on that edge and only rises a full window later. The second pair, like suspend on the final erase cycle, is left to a long random phase. There, the bench's behavioural model decides each coincidence by the rules stated above, and the model is compared against `dataOut` on every cycle.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_SECT_ERASE = 3'd1,
    OP_CHIP_ERASE = 3'd2,
    OP_SUSPEND    = 3'd3,
    OP_RESUME     = 3'd4,
    OP_PROGRAM    = 3'd5,
    OP_RESET      = 3'd6
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ERASING,
    ST_SUSP,
    ST_PGM,
    ST_SPGM
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic addSector;
    logic fillMask;
    logic clearMask;
    logic restartTimer;
    logic stepTimer;
    logic clearErase;
    logic stepErase;
    logic startPgm;
    logic stepPgm;
    logic setFail;
    logic clearFail;
    logic clearToggles;
    logic flip6;
    logic flip2;
  } ctl_strobes_t;

  localparam int POS_TOG6 = 6;
  localparam int POS_FAIL = 5;
  localparam int POS_DQ3  = 3;
  localparam int POS_TOG2 = 2;

endpackage

// File: rtl/fs_datapath.sv
module fs_datapath
  import flash_status_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 12,
  parameter int ERASE_CYC   = 30,
  parameter int PGM_CYC     = 5,
  parameter int PULSE_LIMIT = 40
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctl_strobes_t                   strobes,
  input  logic [$clog2(NUM_SECTORS)-1:0] cmdSector,
  input  logic [DATA_W-1:0]              pgmNew,
  input  logic [DATA_W-1:0]              pgmOld,
  input  logic [$clog2(NUM_SECTORS)-1:0] rdSector,
  input  logic [DATA_W-1:0]              arrayData,
  input  logic                           showStatus,
  input  logic                           dq3Bit,
  output logic                           timerDone,
  output logic                           eraseDone,
  output logic                           pgmDone,
  output logic                           pgmLimit,
  output logic                           failed,
  output logic                           maskAny,
  output logic                           sectorHit,
  output logic [DATA_W-1:0]              dataOut
);

  localparam int SW = $clog2(NUM_SECTORS);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int EW = $clog2(ERASE_CYC + 1);
  localparam int PW = $clog2(PULSE_LIMIT + 1);

  logic [NUM_SECTORS-1:0] eraseMask;
  logic [TW-1:0]          windowCnt;
  logic [EW-1:0]          eraseCnt;
  logic [PW-1:0]          pulseCnt;
  logic                   badPgm;
  logic                   tog6;
  logic                   tog2;
  logic [DATA_W-1:0]      statusWord;

  // one selection flop per sector
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_sector
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    eraseMask[i] <= 1'b0;
      else if (strobes.clearMask)   eraseMask[i] <= 1'b0;
      else if (strobes.fillMask)    eraseMask[i] <= 1'b1;
      else if (strobes.addSector && cmdSector == SW'(i))
                                    eraseMask[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     windowCnt <= '0;
    else if (strobes.restartTimer) windowCnt <= '0;
    else if (strobes.stepTimer)    windowCnt <= windowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   eraseCnt <= '0;
    else if (strobes.clearErase) eraseCnt <= '0;
    else if (strobes.stepErase)  eraseCnt <= eraseCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      badPgm   <= 1'b0;
      failed   <= 1'b0;
    end else if (strobes.startPgm) begin
      pulseCnt <= '0;
      badPgm   <= |(pgmNew & ~pgmOld);
      failed   <= 1'b0;
    end else begin
      if (strobes.stepPgm)   pulseCnt <= pulseCnt + 1'b1;
      if (strobes.setFail)   failed   <= 1'b1;
      if (strobes.clearFail) failed   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (strobes.clearToggles) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else begin
      if (strobes.flip6) tog6 <= ~tog6;
      if (strobes.flip2) tog2 <= ~tog2;
    end
  end

  assign timerDone = windowCnt == TW'(TIMEOUT_CYC - 1);
  assign eraseDone = eraseCnt == EW'(ERASE_CYC - 1);
  assign pgmDone   = !badPgm && pulseCnt == PW'(PGM_CYC - 1);
  assign pgmLimit  = badPgm && pulseCnt == PW'(PULSE_LIMIT - 1);
  assign maskAny   = |eraseMask;
  assign sectorHit = eraseMask[rdSector];

  always_comb begin
    statusWord           = '0;
    statusWord[POS_TOG6] = tog6;
    statusWord[POS_FAIL] = failed;
    statusWord[POS_DQ3]  = dq3Bit;
    statusWord[POS_TOG2] = tog2;
  end

  assign dataOut = showStatus ? statusWord : arrayData;

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    windowCnt <= TW'(TIMEOUT_CYC - 1)); // R4
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PW'(PULSE_LIMIT - 1)); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    failed && !strobes.clearFail && !strobes.startPgm |=> failed); // R7

endmodule

// File: rtl/fs_control.sv
module fs_control
  import flash_status_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [2:0]   cmdCode,
  input  logic         ceN,
  input  logic         oeN,
  input  logic         timerDone,
  input  logic         eraseDone,
  input  logic         pgmDone,
  input  logic         pgmLimit,
  input  logic         failed,
  input  logic         maskAny,
  input  logic         sectorHit,
  output ctl_strobes_t strobes,
  output logic         showStatus,
  output logic         dq3Bit
);

  mode_e state;
  mode_e nextState;
  mode_e retState;
  logic  selNow;
  logic  selPrev;
  logic  readStart;
  logic  isSE, isCE, isSusp, isRes, isPgm, isRst;

  assign selNow    = !ceN && !oeN;
  assign readStart = selNow && !selPrev;  // R9

  assign isSE   = cmdValid && cmdCode == OP_SECT_ERASE;
  assign isCE   = cmdValid && cmdCode == OP_CHIP_ERASE;
  assign isSusp = cmdValid && cmdCode == OP_SUSPEND;
  assign isRes  = cmdValid && cmdCode == OP_RESUME;
  assign isPgm  = cmdValid && cmdCode == OP_PROGRAM;
  assign isRst  = cmdValid && cmdCode == OP_RESET;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      selPrev <= 1'b0;
    end else begin
      state   <= nextState;
      selPrev <= selNow;
    end
  end

  assign retState = (state == ST_SPGM) ? ST_SUSP : ST_IDLE;

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (isSE) begin
          strobes.addSector    = 1'b1;
          strobes.restartTimer = 1'b1;
          strobes.clearErase   = 1'b1;
          strobes.clearToggles = 1'b1;
          nextState            = ST_WAIT;
        end else if (isCE) begin
          strobes.fillMask     = 1'b1;
          strobes.clearErase   = 1'b1;
          strobes.clearToggles = 1'b1;
          nextState            = ST_ERASING;
        end else if (isPgm) begin
          strobes.startPgm     = 1'b1;
          strobes.clearToggles = 1'b1;
          nextState            = ST_PGM;
        end
      end
      ST_WAIT: begin
        if (isSE) begin
          strobes.addSector    = 1'b1;
          strobes.restartTimer = 1'b1;
        end else if (isSusp) begin
          nextState = ST_SUSP;
        end else if (isRst) begin
          strobes.clearMask = 1'b1;
          nextState         = ST_IDLE;
        end else if (timerDone) begin
          nextState = ST_ERASING;
        end else begin
          strobes.stepTimer = 1'b1;
        end
      end
      ST_ERASING: begin
        if (eraseDone) begin
          strobes.clearMask = 1'b1;
          nextState         = ST_IDLE;
        end else if (isSusp) begin
          nextState = ST_SUSP;
        end else begin
          strobes.stepErase = 1'b1;
        end
      end
      ST_SUSP: begin
        if (isRes) begin
          nextState = ST_ERASING;
        end else if (isPgm) begin
          strobes.startPgm     = 1'b1;
          strobes.clearToggles = 1'b1;
          nextState            = ST_SPGM;
        end
      end
      ST_PGM, ST_SPGM: begin
        if (failed) begin
          if (isRst) begin
            strobes.clearFail = 1'b1;
            nextState         = retState;
          end
        end else if (pgmDone) begin
          nextState = retState;
        end else if (pgmLimit) begin
          strobes.setFail = 1'b1;
        end else begin
          strobes.stepPgm = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase

    strobes.flip6 = readStart && (state == ST_WAIT || state == ST_ERASING ||
                                  state == ST_PGM  || state == ST_SPGM);
    strobes.flip2 = readStart && sectorHit &&
                    (state == ST_WAIT || state == ST_ERASING || state == ST_SUSP);
  end

  assign showStatus = (state == ST_WAIT) || (state == ST_ERASING) ||
                      (state == ST_PGM)  || (state == ST_SPGM) ||
                      (state == ST_SUSP && sectorHit);
  assign dq3Bit     = (state == ST_ERASING) || (state == ST_SUSP);

  AST_ERASE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ERASING && !eraseDone && !isSusp |=> state == ST_ERASING); // R6
  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT && !cmdValid && !timerDone |=> state == ST_WAIT); // R4
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !maskAny); // R10
  AST_ERASE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT || state == ST_ERASING || state == ST_SUSP) |-> maskAny); // R2

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_status_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 12,
  parameter int ERASE_CYC   = 30,
  parameter int PGM_CYC     = 5,
  parameter int PULSE_LIMIT = 40
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdValid,
  input  logic [2:0]                     cmdCode,
  input  logic [$clog2(NUM_SECTORS)-1:0] cmdSector,
  input  logic [DATA_W-1:0]              pgmNew,
  input  logic [DATA_W-1:0]              pgmOld,
  input  logic                           ceN,
  input  logic                           oeN,
  input  logic [$clog2(NUM_SECTORS)-1:0] rdSector,
  input  logic [DATA_W-1:0]              arrayData,
  output logic [DATA_W-1:0]              dataOut
);

  ctl_strobes_t strobes;
  logic timerDone, eraseDone, pgmDone, pgmLimit, failed, maskAny, sectorHit;
  logic showStatus, dq3Bit;

  fs_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .ceN        (ceN),
    .oeN        (oeN),
    .timerDone  (timerDone),
    .eraseDone  (eraseDone),
    .pgmDone    (pgmDone),
    .pgmLimit   (pgmLimit),
    .failed     (failed),
    .maskAny    (maskAny),
    .sectorHit  (sectorHit),
    .strobes    (strobes),
    .showStatus (showStatus),
    .dq3Bit     (dq3Bit)
  );

  fs_datapath #(
    .NUM_SECTORS (NUM_SECTORS),
    .DATA_W      (DATA_W),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .ERASE_CYC   (ERASE_CYC),
    .PGM_CYC     (PGM_CYC),
    .PULSE_LIMIT (PULSE_LIMIT)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cmdSector  (cmdSector),
    .pgmNew     (pgmNew),
    .pgmOld     (pgmOld),
    .rdSector   (rdSector),
    .arrayData  (arrayData),
    .showStatus (showStatus),
    .dq3Bit     (dq3Bit),
    .timerDone  (timerDone),
    .eraseDone  (eraseDone),
    .pgmDone    (pgmDone),
    .pgmLimit   (pgmLimit),
    .failed     (failed),
    .maskAny    (maskAny),
    .sectorHit  (sectorHit),
    .dataOut    (dataOut)
  );

endmodule

// File: tb/flash_op_status_test.sv
`timescale 1ns/1ps
module flash_op_status_test;

  localparam int NS = 8;
  localparam int T  = 12;
  localparam int E  = 30;
  localparam int P  = 5;
  localparam int L  = 40;

  localparam int M_IDLE = 0, M_WAIT = 1, M_ERASE = 2, M_SUSP = 3, M_PGM = 4, M_SPGM = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic [2:0] cmdSector = 3'd0;
  logic [7:0] pgmNew = 8'h00;
  logic [7:0] pgmOld = 8'hFF;
  logic       ceN = 1'b1;
  logic       oeN = 1'b1;
  logic [2:0] rdSector = 3'd0;
  logic [7:0] arrayData = 8'hA5;
  logic [7:0] dataOut;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  benchDone = 0;

  always #2.5 clk = ~clk;

  flash_op_status uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdSector(cmdSector), .pgmNew(pgmNew), .pgmOld(pgmOld),
    .ceN(ceN), .oeN(oeN), .rdSector(rdSector), .arrayData(arrayData),
    .dataOut(dataOut)
  );

  // behavioural reference model
  int       mMode, mTimer, mErase, mPulse;
  bit [7:0] mMask;
  bit       mBad, mFail, mT6, mT2, mPrev;
  bit       sel, rs, hit, f6, f2, clr;

  function automatic bit cmdIs(int code);
    return cmdValid && int'(cmdCode) == code;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = M_IDLE; mTimer = 0; mErase = 0; mPulse = 0; mMask = '0;
      mBad = 0; mFail = 0; mT6 = 0; mT2 = 0; mPrev = 0;
    end else begin
      sel = !ceN && !oeN;
      rs  = sel && !mPrev;
      mPrev = sel;
      hit = mMask[rdSector];
      f6 = rs && (mMode == M_WAIT || mMode == M_ERASE || mMode == M_PGM || mMode == M_SPGM);
      f2 = rs && hit && (mMode == M_WAIT || mMode == M_ERASE || mMode == M_SUSP);
      clr = 0;
      case (mMode)
        M_IDLE:
          if (cmdIs(1)) begin
            mMask[cmdSector] = 1; mTimer = 0; mErase = 0; clr = 1; mMode = M_WAIT;
          end else if (cmdIs(2)) begin
            mMask = 8'hFF; mErase = 0; clr = 1; mMode = M_ERASE;
          end else if (cmdIs(5)) begin
            mPulse = 0; mBad = (pgmNew & ~pgmOld) != 0; mFail = 0; clr = 1; mMode = M_PGM;
          end
        M_WAIT:
          if (cmdIs(1)) begin mMask[cmdSector] = 1; mTimer = 0; end
          else if (cmdIs(3)) mMode = M_SUSP;
          else if (cmdIs(6)) begin mMask = '0; mMode = M_IDLE; end
          else if (mTimer == T - 1) mMode = M_ERASE;
          else mTimer++;
        M_ERASE:
          if (mErase == E - 1) begin mMask = '0; mMode = M_IDLE; end
          else if (cmdIs(3)) mMode = M_SUSP;
          else mErase++;
        M_SUSP:
          if (cmdIs(4)) mMode = M_ERASE;
          else if (cmdIs(5)) begin
            mPulse = 0; mBad = (pgmNew & ~pgmOld) != 0; mFail = 0; clr = 1; mMode = M_SPGM;
          end
        default: begin
          if (mFail) begin
            if (cmdIs(6)) begin mFail = 0; mMode = (mMode == M_SPGM) ? M_SUSP : M_IDLE; end
          end else if (!mBad && mPulse == P - 1) mMode = (mMode == M_SPGM) ? M_SUSP : M_IDLE;
          else if (mBad && mPulse == L - 1) mFail = 1;
          else mPulse++;
        end
      endcase
      if (clr) begin mT6 = 0; mT2 = 0; end
      else begin
        if (f6) mT6 = !mT6;
        if (f2) mT2 = !mT2;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!benchDone) begin
      bit show;
      logic [7:0] expv;
      show = (mMode == M_WAIT || mMode == M_ERASE || mMode == M_PGM || mMode == M_SPGM) ||
             (mMode == M_SUSP && mMask[rdSector]);
      expv = show ? {1'b0, mT6, mFail, 1'b0, (mMode == M_ERASE || mMode == M_SUSP), mT2, 2'b00}
                  : arrayData;
      nChecks++;
      if (!show && dataOut !== expv) begin
        nErrors++;
        $display("FAIL R1 array read at %0t: actual %h expected %h", $time, dataOut, expv);
      end else if (show && dataOut !== expv) begin
        nErrors++;
        if (dataOut[6] !== expv[6])
          $display("FAIL R3 bit6 at %0t: actual %b expected %b", $time, dataOut[6], expv[6]);
        else if (dataOut[2] !== expv[2])
          $display("FAIL R2 bit2 at %0t: actual %b expected %b", $time, dataOut[2], expv[2]);
        else if (dataOut[5] !== expv[5])
          $display("FAIL R7 bit5 at %0t: actual %b expected %b", $time, dataOut[5], expv[5]);
        else if (dataOut[3] !== expv[3])
          $display("FAIL R4 bit3 at %0t: actual %b expected %b", $time, dataOut[3], expv[3]);
        else
          $display("FAIL R11 status byte at %0t: actual %h expected %h", $time, dataOut, expv);
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    #1;
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [2:0] code, logic [2:0] sec, logic [7:0] nv, logic [7:0] ov);
    @(negedge clk);
    cmdValid = 1; cmdCode = code; cmdSector = sec; pgmNew = nv; pgmOld = ov;
    @(negedge clk);
    cmdValid = 0; cmdCode = 3'd0;
  endtask

  // byOe: chip select falls first, output enable last; otherwise the reverse
  task automatic readCycle(logic [2:0] sec, bit byOe);
    @(negedge clk);
    rdSector = sec;
    if (byOe) ceN = 0; else oeN = 0;
    @(negedge clk);
    if (byOe) oeN = 0; else ceN = 0;
    @(negedge clk);
    ceN = 1; oeN = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset state", dataOut, 8'hA5);
    rstN = 1;
    idle(2);
    check("R1 idle read", dataOut, 8'hA5);

    // sector erase, two reads: sector 2 selected, sector 5 not
    issue(3'd1, 3'd2, 8'h00, 8'h00);
    readCycle(3'd2, 1);
    readCycle(3'd5, 0);
    check("R2/R3/R9 toggles after two reads", dataOut, 8'h04);
    idle(T - 8);
    issue(3'd1, 3'd6, 8'h00, 8'h00);    // lands on window expiry edge
    check("R4 window restarted", dataOut[3], 1'b0);
    idle(T - 1);
    check("R4 window still open", dataOut[3], 1'b0);
    idle(1);
    check("R4 window closed", dataOut[3], 1'b1);

    issue(3'd5, 3'd0, 8'h00, 8'hFF);    // ignored while erasing
    readCycle(3'd6, 1);
    check("R6 program ignored during erase, R2 sector 6 added", dataOut, 8'h48);

    issue(3'd3, 3'd0, 8'h00, 8'h00);
    readCycle(3'd3, 0);
    check("R1 suspend read of unselected sector", dataOut, 8'hA5);
    readCycle(3'd2, 1);
    check("R3 bit6 held, R2 bit2 toggles in suspend", dataOut, 8'h4C);

    issue(3'd5, 3'd0, 8'h01, 8'h00);    // impossible program from suspend
    idle(L + 2);
    check("R7 fail in suspend program", dataOut[5], 1'b1);
    issue(3'd6, 3'd0, 8'h00, 8'h00);
    readCycle(3'd2, 0);
    check("R8 reset back to suspend", dataOut & 8'h28, 8'h08);
    readCycle(3'd0, 0);
    check("R8 suspend array read", dataOut, 8'hA5);

    issue(3'd4, 3'd0, 8'h00, 8'h00);
    idle(E + 4);
    check("R10 erase complete", dataOut, 8'hA5);
    readCycle(3'd2, 1);
    check("R10 selection cleared", dataOut, 8'hA5);

    issue(3'd2, 3'd0, 8'h00, 8'h00);
    check("R5 chip erase bit3 at once", dataOut, 8'h08);
    readCycle(3'd7, 0);
    check("R5 all sectors selected", dataOut, 8'h4C);
    idle(E + 2);
    check("R10 chip erase complete", dataOut, 8'hA5);

    issue(3'd5, 3'd0, 8'h00, 8'hFF);
    check("R11 toggles cleared at program", dataOut, 8'h00);
    idle(P - 1);
    check("R7 program still busy", dataOut, 8'h00);
    idle(1);
    check("R7 program done", dataOut, 8'hA5);

    issue(3'd5, 3'd0, 8'h80, 8'h7F);
    idle(L);
    check("R7 fail flag", dataOut, 8'h20);
    readCycle(3'd1, 0);
    check("R7 toggle continues after fail", dataOut, 8'h60);
    issue(3'd6, 3'd0, 8'h00, 8'h00);
    check("R8 reset to array read", dataOut, 8'hA5);

    issue(3'd7, 3'd3, 8'h00, 8'h00);
    issue(3'd3, 3'd3, 8'h00, 8'h00);
    issue(3'd4, 3'd3, 8'h00, 8'h00);
    readCycle(3'd3, 1);
    check("R12 invalid commands ignored", dataOut, 8'hA5);

    // random phase, judged by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ceN       = ($urandom % 3) != 0;
      oeN       = ($urandom % 3) != 0;
      cmdValid  = ($urandom % 10) == 0;
      cmdCode   = 3'($urandom_range(1, 7));
      cmdSector = 3'($urandom);
      pgmOld    = ($urandom % 2) ? 8'hFF : 8'($urandom);
      pgmNew    = 8'($urandom);
      rdSector  = 3'($urandom);
      arrayData = 8'($urandom);
    end
    @(negedge clk);
    cmdValid = 0; ceN = 1; oeN = 1;
    idle(3);
    benchDone = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule